// File: doc/BRIEF.md
# Abortable Four-Beat Burst Bus Master

This block is the bus-facing sequencer that moves whole cache lines between a cache controller and a single-master external bus. A cache controller hands it one request: a line read (a fill), or a line write (a copy-back or write-back) together with all the write data. The sequencer opens the transfer with an address-start strobe. It then moves one data word each time the bus target signals a ready beat, and it flags the final beat of the line.

The external system can take the bus away at any moment by asserting a back-off input. The master then leaves the bus on the very next clock and drives all of its outputs to the idle state. It does not forget how far the burst got. When back-off is released, it issues a fresh address-start for the first beat that never completed and transfers only the beats that remain. Read words that were already handed to the cache are not handed over again.

A request can be marked as locked (for example a read-modify-write). The lock marking stays with the sequence through every abort and resume.

Top module: `burst_master`

## Requirements
- R1: When bus_backoff is high at a rising edge while bus_own is high, bus_own is low after that edge. Whenever bus_own is low, bus_start, bus_last, bus_write and bus_lock are 0, and bus_addr and bus_wdata are all zeros.
- R2: A line holds BEATS words of DATA_W bits. Beat k has the address (req_addr with its low log2(BEATS*DATA_W/8) bits cleared) + k*DATA_W/8. Beats go in ascending order. bus_last is high exactly in data cycles of the final beat (k = BEATS-1).
- R3: After a read burst is aborted, the next bus_start carries the address of the first unaccepted beat. Only the remaining beats follow. The number of address starts per request is 1 plus the number of aborts.
- R4: In a write burst, bus_wdata during the data cycles of beat k equals req_wdata[k*DATA_W +: DATA_W] as captured at the request. After an abort, the write resumes at the first unaccepted beat.
- R5: A bus_ready that is high in the same cycle as bus_backoff is ignored: that beat is not counted and is transferred again after the resume.
- R6: Each accepted read beat is reported exactly once, one cycle after its acceptance. rsp_rvalid goes high, rsp_beat carries the beat index k, and rsp_rdata carries the word sampled with it. Write requests never raise rsp_rvalid.
- R7: rsp_done is a single-cycle pulse one cycle after the final beat is accepted. req_ready is high only while no request is in progress. A request is taken when req_valid and req_ready are both high at a rising edge.
- R8: For a request with req_lock high, bus_lock is high in every cycle in which the master owns the bus, including cycles after a resume.
- R9: Back-off sampled during the address-start cycle aborts with no beat done. The resume reissues the same address.
- R10: While rst_n is low, req_ready is 1 and bus_own, rsp_rvalid and rsp_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = line write, 0 = line read |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_addr | input | ADDR_W | Any byte address inside the line |
| req_wdata | input | BEATS*DATA_W | Write data, beat k in slice k |
| rsp_rvalid | output | 1 | A read beat is being reported |
| rsp_beat | output | CNT_W | Index of the reported beat |
| rsp_rdata | output | DATA_W | Read word of the reported beat |
| rsp_done | output | 1 | Line transfer complete |
| bus_start | output | 1 | Address-start strobe |
| bus_addr | output | ADDR_W | Beat address, zero when not owning |
| bus_write | output | 1 | Direction of the owned cycle |
| bus_lock | output | 1 | Locked-cycle indication |
| bus_last | output | 1 | Final beat of the line |
| bus_own | output | 1 | Output enable for the bus pins |
| bus_wdata | output | DATA_W | Write word of the current beat |
| bus_rdata | input | DATA_W | Read word from the target |
| bus_ready | input | 1 | Target completes the current beat |
| bus_backoff | input | 1 | Forces the master off the bus |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, DATA_W = 32, BEATS = 4. With these values, aborts at every one of the four beat positions and at the address-start cycle can all be tested in turn, for both directions and with the lock on or off. The 32-bit bus lets each word carry a value unique to its line and beat. Misordered, repeated or skipped beats therefore show up directly in the data compared.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } bm_state_e;
endpackage

// File: rtl/bm_beat_track.sv
module bm_beat_track #(
  parameter int BEATS = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] beat,
  output logic             is_last
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       beat <= '0;
    else if (clear)   beat <= '0;
    else if (advance) beat <= beat + 1'b1;
  end

  assign is_last = (beat == LAST_IDX);
endmodule

// File: rtl/bm_seq.sv
module bm_seq
  import bm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_go,
  input  logic backoff,
  input  logic ready,
  input  logic is_last,
  output logic idle,
  output logic issue,
  output logic own,
  output logic data_ph,
  output logic accept,
  output logic finish
);
  bm_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_go) state_nx = ST_ADDR;
      ST_ADDR: state_nx = backoff ? ST_HOLD : ST_DATA;
      ST_DATA: begin
        if (backoff)                state_nx = ST_HOLD;
        else if (ready && is_last)  state_nx = ST_IDLE;
      end
      ST_HOLD: if (!backoff) state_nx = ST_ADDR;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign idle    = (state == ST_IDLE);
  assign issue   = (state == ST_ADDR);
  assign data_ph = (state == ST_DATA);
  assign own     = issue || data_ph;
  // back-off wins over a ready in the same cycle
  assign accept  = data_ph && ready && !backoff;
  assign finish  = accept && is_last;
endmodule

// File: rtl/burst_master.sv
module burst_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_lock,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [BEATS*DATA_W-1:0] req_wdata,
  output logic                    rsp_rvalid,
  output logic [CNT_W-1:0]        rsp_beat,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_done,
  output logic                    bus_start,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_write,
  output logic                    bus_lock,
  output logic                    bus_last,
  output logic                    bus_own,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    bus_ready,
  input  logic                    bus_backoff
);
  localparam int BYTES_W    = DATA_W / 8;
  localparam int LSB_W      = $clog2(BYTES_W);
  localparam int LINE_BYTES = BEATS * BYTES_W;

  // line base plus beat offset
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [CNT_W-1:0]  k);
    logic [ADDR_W-1:0] mask;
    mask = ~ADDR_W'(LINE_BYTES - 1);
    return (base & mask) | (ADDR_W'(k) << LSB_W);
  endfunction

  logic                    req_go;
  logic                    idle, issue, own, data_ph;
  logic                    beat_accept, beat_finish;
  logic [CNT_W-1:0]        beat;
  logic                    is_last;
  logic [ADDR_W-1:0]       base_q;
  logic                    wr_q, lock_q;
  logic [BEATS*DATA_W-1:0] wdata_q;

  assign req_go = req_valid && idle;

  bm_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_go  (req_go),
    .backoff (bus_backoff),
    .ready   (bus_ready),
    .is_last (is_last),
    .idle    (idle),
    .issue   (issue),
    .own     (own),
    .data_ph (data_ph),
    .accept  (beat_accept),
    .finish  (beat_finish)
  );

  bm_beat_track #(.BEATS(BEATS), .CNT_W(CNT_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (req_go),
    .advance (beat_accept),
    .beat    (beat),
    .is_last (is_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      wr_q    <= 1'b0;
      lock_q  <= 1'b0;
      wdata_q <= '0;
    end else if (req_go) begin
      base_q  <= req_addr;
      wr_q    <= req_write;
      lock_q  <= req_lock;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rvalid <= 1'b0;
      rsp_beat   <= '0;
      rsp_rdata  <= '0;
      rsp_done   <= 1'b0;
    end else begin
      rsp_rvalid <= beat_accept && !wr_q;
      rsp_done   <= beat_finish;
      if (beat_accept && !wr_q) begin
        rsp_beat  <= beat;
        rsp_rdata <= bus_rdata;
      end
    end
  end

  assign req_ready = idle;
  assign bus_own   = own;
  assign bus_start = issue;
  assign bus_addr  = own ? beat_addr(base_q, beat) : '0;
  assign bus_write = own && wr_q;
  assign bus_lock  = own && lock_q;
  assign bus_last  = data_ph && is_last;
  assign bus_wdata = (data_ph && wr_q) ? wdata_q[beat*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/burst_master_chk.sv
module burst_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_backoff,
  input logic              bus_own,
  input logic              bus_start,
  input logic              bus_last,
  input logic              bus_lock,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_rvalid,
  input logic              rsp_done,
  input logic              req_ready,
  input logic              beat_accept,
  input logic              beat_finish,
  input logic              lock_q
);
  a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && bus_backoff) |=> !bus_own);

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (bus_addr == '0 && bus_wdata == '0 && !bus_start && !bus_last && !bus_lock));

  a_r2_last_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_last |-> (bus_own && !bus_start));

  a_r5_backoff_blocks_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_backoff |-> !beat_accept);

  a_r6_report_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rvalid |-> $past(beat_accept));

  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(beat_finish) && req_ready));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r8_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(lock_q));
endmodule

bind burst_master burst_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_backoff (bus_backoff),
  .bus_own     (bus_own),
  .bus_start   (bus_start),
  .bus_last    (bus_last),
  .bus_lock    (bus_lock),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rsp_rvalid  (rsp_rvalid),
  .rsp_done    (rsp_done),
  .req_ready   (req_ready),
  .beat_accept (beat_accept),
  .beat_finish (beat_finish),
  .lock_q      (lock_q)
);

// File: tb/burst_master_test.sv
module burst_master_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int CW = 2;
  localparam int NV = 8;

  // {write, lock, addr_abort, abort_beat[2:0] (4 = none), hold_len[3:0], line[5:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 3'd4, 4'd0, 6'd1},
    {1'b0, 1'b0, 1'b0, 3'd0, 4'd2, 6'd2},
    {1'b0, 1'b1, 1'b0, 3'd2, 4'd1, 6'd3},
    {1'b0, 1'b0, 1'b1, 3'd3, 4'd3, 6'd4},
    {1'b1, 1'b0, 1'b0, 3'd4, 4'd0, 6'd5},
    {1'b1, 1'b0, 1'b0, 3'd1, 4'd2, 6'd6},
    {1'b1, 1'b1, 1'b1, 3'd3, 4'd1, 6'd7},
    {1'b0, 1'b0, 1'b1, 3'd4, 4'd2, 6'd8}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic             req_lock = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [NB*DW-1:0] req_wdata = '0;
  logic             rsp_rvalid;
  logic [CW-1:0]    rsp_beat;
  logic [DW-1:0]    rsp_rdata;
  logic             rsp_done;
  logic             bus_start, bus_write, bus_lock, bus_last, bus_own;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata;
  logic [DW-1:0]    bus_rdata = '0;
  logic             bus_ready = 1'b0;
  logic             bus_backoff = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_master uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_lock(req_lock), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rvalid(rsp_rvalid), .rsp_beat(rsp_beat), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_lock(bus_lock), .bus_last(bus_last),
    .bus_own(bus_own), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_backoff(bus_backoff)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] line_base(input int line);
    return 32'h1000_0000 + (line << 4);
  endfunction

  function automatic logic [DW-1:0] rd_word(input int line, input int k);
    return 32'hC300_0000 ^ (line * 32'h100) + k;
  endfunction

  function automatic logic [DW-1:0] wr_word(input int line, input int k);
    return 32'h5A00_0000 ^ (line * 32'h1000) ^ (k * 32'h0101);
  endfunction

  task automatic run_vec(input logic [15:0] v);
    bit wr, lk, aab;
    int ab_beat, hold_len, line;
    int done_k, rsp_k, hold, starts, cyc;
    bit aborted, aab_used, prev_boff, done_seen;
    wr = v[15]; lk = v[14]; aab = v[13];
    ab_beat = int'(v[12:10]); hold_len = int'(v[9:6]); line = int'(v[5:0]);
    done_k = 0; rsp_k = 0; hold = 0; starts = 0;
    aborted = 0; aab_used = 0; prev_boff = 0; done_seen = 0;

    chk(req_ready == 1'b1, "R7 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_lock = lk;
    req_addr = line_base(line) | 32'h0000_000C;  // unaligned on purpose (R2)
    for (int k = 0; k < NB; k++) req_wdata[k*DW +: DW] = wr_word(line, k);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = '0; req_wdata = '0;

    for (cyc = 0; cyc < 80 && !done_seen; cyc++) begin
      if (prev_boff) chk(!bus_own, "R1 off bus next clock", 64'(bus_own), 64'd0);
      if (!bus_own)
        chk(bus_addr == '0 && bus_wdata == '0 && !bus_start && !bus_lock && !bus_last,
            "R1 idle pins", 64'(bus_addr), 64'd0);
      else
        chk(!req_ready, "R7 ready low while busy", 64'(req_ready), 64'd0);
      if (rsp_rvalid) begin
        chk(!wr, "R6 no read report on write", 64'(rsp_rvalid), 64'd0);
        chk(rsp_beat == CW'(rsp_k) && rsp_rdata == rd_word(line, rsp_k),
            "R6 read beat once in order", {32'(rsp_beat), rsp_rdata},
            {32'(rsp_k), rd_word(line, rsp_k)});
        rsp_k++;
      end
      if (rsp_done) done_seen = 1'b1;

      bus_backoff = 1'b0; bus_ready = 1'b0; bus_rdata = '0;
      if (hold > 0) begin
        bus_backoff = 1'b1; hold--;
      end else if (bus_start) begin
        starts++;
        chk(bus_addr == line_base(line) + 32'(done_k * 4), "R3 R9 restart address",
            64'(bus_addr), 64'(line_base(line) + 32'(done_k * 4)));
        chk(bus_lock == lk && bus_write == wr, "R8 lock on start", 64'(bus_lock), 64'(lk));
        if (aab && !aab_used) begin
          bus_backoff = 1'b1; aab_used = 1'b1; hold = hold_len;
        end
      end else if (bus_own) begin
        chk(bus_addr == line_base(line) + 32'(done_k * 4), "R2 beat address",
            64'(bus_addr), 64'(line_base(line) + 32'(done_k * 4)));
        chk(bus_last == (done_k == NB - 1), "R2 last flag", 64'(bus_last), 64'(done_k == NB - 1));
        chk(bus_lock == lk, "R8 lock in data", 64'(bus_lock), 64'(lk));
        if (wr) chk(bus_wdata == wr_word(line, done_k), "R4 write word",
                    64'(bus_wdata), 64'(wr_word(line, done_k)));
        bus_ready = 1'b1;
        bus_rdata = rd_word(line, done_k);
        if (!aborted && done_k == ab_beat) begin
          bus_backoff = 1'b1;  // ready in the same cycle must be ignored (R5)
          bus_rdata = 32'hDEAD_BEEF;
          aborted = 1'b1; hold = hold_len;
        end else begin
          done_k++;
        end
      end
      prev_boff = bus_backoff && bus_own;
      @(negedge clk);
    end
    bus_backoff = 1'b0; bus_ready = 1'b0;
    chk(done_seen, "R7 done seen", 64'(done_seen), 64'd1);
    chk(done_k == NB, "R3 R5 beats transferred", 64'(done_k), 64'(NB));
    chk(rsp_k == (wr ? 0 : NB), "R6 read report count", 64'(rsp_k), 64'(wr ? 0 : NB));
    chk(starts == 1 + int'(ab_beat < NB) + int'(aab), "R3 start count",
        64'(starts), 64'(1 + int'(ab_beat < NB) + int'(aab)));
    chk(!rsp_done && req_ready, "R7 done single pulse", 64'(rsp_done), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
    chk(!bus_own && !rsp_rvalid && !rsp_done, "R10 quiet in reset",
        {61'd0, bus_own, rsp_rvalid, rsp_done}, 64'd0);
    req_valid = 1'b1;
    @(negedge clk);
    chk(!bus_own, "R10 request ignored in reset", 64'(bus_own), 64'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i]);
      @(negedge clk);
    end

    // back-off while idle keeps the pins quiet (R1)
    bus_backoff = 1'b1;
    @(negedge clk);
    chk(!bus_own && bus_addr == '0, "R1 idle with backoff", 64'(bus_own), 64'd0);
    bus_backoff = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule